// File: doc/BRIEF.md
# Snooping Legacy Video Decode Filter

This block sits in the downstream-claim path of a bridge. For every host cycle it decides whether a cycle in the legacy video I/O or memory window goes to the graphics device below the bridge. If it does not claim the cycle, the cycle stays unclaimed so that a subtractive decoder elsewhere can pick it up. This lets a separate monochrome adapter on the subtractive path work alongside a colour graphics device behind the bridge.

The block does not treat the legacy window as one fixed block. It keeps shadow copies of the graphics controller's two address-select settings:
- the port-block select bit of the miscellaneous output register;
- the two memory-map bits of graphics register 6.

It captures writes to these registers as they pass downstream, and it gates each claim on the shadow values. To follow the indexed graphics register, it also shadows the graphics index register.

A cycle is presented as a one-cycle strobe. The strobe carries:
- a byte address for lane 0 (lane k targets address + k);
- an I/O-or-memory flag and a write flag;
- per-lane byte enables and write data.

The bridge's VGA-enable configuration bit is a level input. The claim output is combinational, so the bridge can use it in the same cycle.

Top module: `vga_claim_filter`

## Requirements
- R1: After reset the port-select shadow is 0, the memory-map shadow is 00 and the index shadow is 0. With enable set, ports 0x3B0–0x3BF are claimed, ports 0x3D0–0x3DF are not claimed, and all memory in 0xA0000–0xBFFFF is claimed.
- R2: While the enable input is 0, no cycle is claimed and no write changes any shadow.
- R3: An enabled I/O write whose lane hits port 0x3C2 loads that lane's data bit 0 into the port-select shadow. With the shadow at 0, ports 0x3B0–0x3BF are claimed and ports 0x3D0–0x3DF are not. With the shadow at 1, the reverse holds.
- R4: While enable is set, ports 0x3C0–0x3CF are claimed whatever the port-select shadow holds.
- R5: The memory-map shadow selects the claimed memory as follows:
  - 00 claims 0xA0000–0xBFFFF;
  - 01 claims 0xA0000–0xAFFFF;
  - 10 claims 0xB0000–0xB7FFF;
  - 11 claims 0xB8000–0xBFFFF.
- R6: An enabled I/O write to port 0x3CE loads data bits 2:0 into the index shadow. An enabled I/O write to port 0x3CF loads data bits 3:2 into the memory-map shadow, but only when the index in force is 6. Reads change nothing.
- R7: A write at address 0x3CE with both byte lanes enabled sets the index from the low byte. In the same cycle it treats the high byte as a 0x3CF data write under that new index.
- R8: A claim uses the shadow values from before the current cycle. A snooped update first affects claims in the next cycle.
- R9: The following cycles are never claimed: I/O outside 0x3B0–0x3DF and memory outside 0xA0000–0xBFFFF. A byte lane with its enable low updates no shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycValid | input | 1 | A host cycle is presented this clock |
| cycIsIo | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cycWrite | input | 1 | 1 = write, 0 = read |
| cycAddr | input | ADDR_W | Byte address of lane 0 |
| cycByteEn | input | DATA_W/8 | Per-lane byte enables |
| cycWrData | input | DATA_W | Write data, lane k in bits 8k+7:8k |
| vgaEnable | input | 1 | Bridge legacy-video forwarding enable |
| claim | output | 1 | Forward this cycle downstream |

## Verification
The decode is swept under every combination of port-select (2 values) and memory-map setting (4 values), with enable both set and clear. Each sweep covers every I/O port from 0x3A0 to 0x3EF and memory addresses stepped through 0x9F000–0xC0FFF, plus each range edge. This separates each sub-range's gating from the fixed control-port block and from the out-of-window space.

Targeted write sequences cover the remaining behaviour:
- data writes under a wrong index;
- reads of the index port;
- writes while disabled;
- writes with off-lane byte enables;
- split-lane index writes.

Each sequence is followed at once by decode checks, which shows whether the update happens, whether it is suppressed, and whether it first takes effect in the next cycle.

// File: rtl/vga_claim_pkg.sv
package vga_claim_pkg;

  localparam logic [15:0] PORT_MISC_WR = 16'h03C2;
  localparam logic [15:0] PORT_GR_IDX  = 16'h03CE;
  localparam logic [15:0] PORT_GR_DAT  = 16'h03CF;
  localparam logic [2:0]  GR_MAP_INDEX = 3'd6;

  localparam logic [15:0] IO_MONO_LO  = 16'h03B0;
  localparam logic [15:0] IO_MONO_HI  = 16'h03BF;
  localparam logic [15:0] IO_CTRL_LO  = 16'h03C0;
  localparam logic [15:0] IO_CTRL_HI  = 16'h03CF;
  localparam logic [15:0] IO_COLOR_LO = 16'h03D0;
  localparam logic [15:0] IO_COLOR_HI = 16'h03DF;

  localparam logic [19:0] MEM_GFX_LO  = 20'hA0000;
  localparam logic [19:0] MEM_GFX_HI  = 20'hAFFFF;
  localparam logic [19:0] MEM_MONO_LO = 20'hB0000;
  localparam logic [19:0] MEM_MONO_HI = 20'hB7FFF;
  localparam logic [19:0] MEM_TEXT_LO = 20'hB8000;
  localparam logic [19:0] MEM_TEXT_HI = 20'hBFFFF;

  typedef enum logic [1:0] {
    MAP_WHOLE    = 2'b00,
    MAP_GFX      = 2'b01,
    MAP_MONO     = 2'b10,
    MAP_TEXT     = 2'b11
  } memMap_e;

  // strobes from snoop control to the shadow datapath
  typedef struct packed {
    logic       miscWr;
    logic       miscVal;
    logic       idxWr;
    logic [2:0] idxVal;
    logic       mapWr;
    logic [1:0] mapVal;
  } snoopStb_t;

endpackage

// File: rtl/vga_snoop_ctrl.sv
module vga_snoop_ctrl
  import vga_claim_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 2
) (
  input  logic                 cycValid,
  input  logic                 cycIsIo,
  input  logic                 cycWrite,
  input  logic [ADDR_W-1:0]    cycAddr,
  input  logic [LANES-1:0]     cycByteEn,
  input  logic [8*LANES-1:0]   cycWrData,
  input  logic                 vgaEnable,
  input  logic [2:0]           idxShadow,
  output snoopStb_t            stb
);

  logic              snoopOk;
  logic [ADDR_W-1:0] laneAddr [LANES];
  logic [7:0]        laneByte [LANES];
  logic [LANES-1:0]  laneHit;

  assign snoopOk = cycValid && cycIsIo && cycWrite && vgaEnable;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneAddr[k] = cycAddr + ADDR_W'(k);
    assign laneByte[k] = cycWrData[8*k +: 8];
    assign laneHit[k]  = snoopOk && cycByteEn[k];
  end

  // Lanes are taken in ascending order so an index written on a lower lane
  // governs a data byte on a higher lane in the same cycle.
  always_comb begin
    logic [2:0] curIdx;
    stb    = '0;
    curIdx = idxShadow;
    for (int k = 0; k < LANES; k++) begin
      if (laneHit[k]) begin
        if (laneAddr[k] == ADDR_W'(PORT_MISC_WR)) begin
          stb.miscWr  = 1'b1;
          stb.miscVal = laneByte[k][0];
        end
        if (laneAddr[k] == ADDR_W'(PORT_GR_IDX)) begin
          stb.idxWr  = 1'b1;
          stb.idxVal = laneByte[k][2:0];
          curIdx     = laneByte[k][2:0];
        end
        if (laneAddr[k] == ADDR_W'(PORT_GR_DAT) && curIdx == GR_MAP_INDEX) begin
          stb.mapWr  = 1'b1;
          stb.mapVal = laneByte[k][3:2];
        end
      end
    end
  end

endmodule

// File: rtl/vga_shadow_dp.sv
module vga_shadow_dp
  import vga_claim_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  snoopStb_t         stb,
  input  logic              cycValid,
  input  logic              cycIsIo,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic              vgaEnable,
  output logic              claim,
  output logic              ioSel,
  output memMap_e           memMap,
  output logic [2:0]        idxShadow
);

  logic inMonoIo, inCtrlIo, inColorIo;
  logic inGfxMem, inMonoMem, inTextMem;
  logic ioClaim, memClaim;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioSel     <= 1'b0;
      memMap    <= MAP_WHOLE;
      idxShadow <= 3'd0;
    end else begin
      if (stb.miscWr) ioSel     <= stb.miscVal;
      if (stb.idxWr)  idxShadow <= stb.idxVal;
      if (stb.mapWr)  memMap    <= memMap_e'(stb.mapVal);
    end
  end

  assign inMonoIo  = cycAddr >= ADDR_W'(IO_MONO_LO)  && cycAddr <= ADDR_W'(IO_MONO_HI);
  assign inCtrlIo  = cycAddr >= ADDR_W'(IO_CTRL_LO)  && cycAddr <= ADDR_W'(IO_CTRL_HI);
  assign inColorIo = cycAddr >= ADDR_W'(IO_COLOR_LO) && cycAddr <= ADDR_W'(IO_COLOR_HI);
  assign inGfxMem  = cycAddr >= ADDR_W'(MEM_GFX_LO)  && cycAddr <= ADDR_W'(MEM_GFX_HI);
  assign inMonoMem = cycAddr >= ADDR_W'(MEM_MONO_LO) && cycAddr <= ADDR_W'(MEM_MONO_HI);
  assign inTextMem = cycAddr >= ADDR_W'(MEM_TEXT_LO) && cycAddr <= ADDR_W'(MEM_TEXT_HI);

  assign ioClaim = inCtrlIo || (inMonoIo && !ioSel) || (inColorIo && ioSel);

  always_comb begin
    unique case (memMap)
      MAP_WHOLE: memClaim = inGfxMem || inMonoMem || inTextMem;
      MAP_GFX:   memClaim = inGfxMem;
      MAP_MONO:  memClaim = inMonoMem;
      MAP_TEXT:  memClaim = inTextMem;
      default:   memClaim = 1'b0;
    endcase
  end

  assign claim = cycValid && vgaEnable && (cycIsIo ? ioClaim : memClaim);

endmodule

// File: rtl/vga_claim_filter.sv
module vga_claim_filter
  import vga_claim_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycValid,
  input  logic              cycIsIo,
  input  logic              cycWrite,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [DATA_W/8-1:0] cycByteEn,
  input  logic [DATA_W-1:0] cycWrData,
  input  logic              vgaEnable,
  output logic              claim
);

  localparam int LANES = DATA_W / 8;

  snoopStb_t  stb;
  logic       ioSel;
  memMap_e    memMap;
  logic [2:0] idxShadow;

  vga_snoop_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .cycValid  (cycValid),
    .cycIsIo   (cycIsIo),
    .cycWrite  (cycWrite),
    .cycAddr   (cycAddr),
    .cycByteEn (cycByteEn),
    .cycWrData (cycWrData),
    .vgaEnable (vgaEnable),
    .idxShadow (idxShadow),
    .stb       (stb)
  );

  vga_shadow_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cycValid  (cycValid),
    .cycIsIo   (cycIsIo),
    .cycAddr   (cycAddr),
    .vgaEnable (vgaEnable),
    .claim     (claim),
    .ioSel     (ioSel),
    .memMap    (memMap),
    .idxShadow (idxShadow)
  );

endmodule

// File: rtl/vga_claim_checker.sv
module vga_claim_checker
  import vga_claim_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                cycValid,
  input logic                cycIsIo,
  input logic                cycWrite,
  input logic [ADDR_W-1:0]   cycAddr,
  input logic [DATA_W/8-1:0] cycByteEn,
  input logic [DATA_W-1:0]   cycWrData,
  input logic                vgaEnable,
  input logic                claim,
  input logic                ioSel,
  input logic [1:0]          memMap
);

  logic ioMono, ioColor, ioCtrl, ioOut, memOut, memB;

  assign ioMono  = cycAddr >= ADDR_W'(16'h3B0) && cycAddr <= ADDR_W'(16'h3BF);
  assign ioCtrl  = cycAddr >= ADDR_W'(16'h3C0) && cycAddr <= ADDR_W'(16'h3CF);
  assign ioColor = cycAddr >= ADDR_W'(16'h3D0) && cycAddr <= ADDR_W'(16'h3DF);
  assign ioOut   = cycAddr <  ADDR_W'(16'h3B0) || cycAddr >  ADDR_W'(16'h3DF);
  assign memOut  = cycAddr <  ADDR_W'(20'hA0000) || cycAddr > ADDR_W'(20'hBFFFF);
  assign memB    = cycAddr >= ADDR_W'(20'hB0000) && cycAddr <= ADDR_W'(20'hBFFFF);

  a_r2_no_claim_off: assert property (@(posedge clk) disable iff (!rstN)
    !vgaEnable |-> !claim);

  a_r2_shadow_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    !vgaEnable |=> ($stable(ioSel) && $stable(memMap)));

  a_r3_mono_gated: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycIsIo && ioMono && ioSel) |-> !claim);

  a_r3_color_gated: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycIsIo && ioColor && !ioSel) |-> !claim);

  a_r4_ctrl_claimed: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && vgaEnable && cycIsIo && ioCtrl) |-> claim);

  a_r5_gfx_map_skips_b: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !cycIsIo && memMap == 2'b01 && memB) |-> !claim);

  a_r8_misc_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycIsIo && cycWrite && vgaEnable && cycByteEn[0] &&
     cycAddr == ADDR_W'(16'h3C2)) |=> (ioSel == $past(cycWrData[0])));

  a_r9_io_outside: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycIsIo && ioOut) |-> !claim);

  a_r9_mem_outside: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !cycIsIo && memOut) |-> !claim);

endmodule

bind vga_claim_filter vga_claim_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cycValid  (cycValid),
  .cycIsIo   (cycIsIo),
  .cycWrite  (cycWrite),
  .cycAddr   (cycAddr),
  .cycByteEn (cycByteEn),
  .cycWrData (cycWrData),
  .vgaEnable (vgaEnable),
  .claim     (claim),
  .ioSel     (ioSel),
  .memMap    (memMap)
);

// File: tb/vga_claim_filter_bench.sv
module vga_claim_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycValid = 1'b0;
  logic        cycIsIo = 1'b0;
  logic        cycWrite = 1'b0;
  logic [31:0] cycAddr = '0;
  logic [1:0]  cycByteEn = '0;
  logic [15:0] cycWrData = '0;
  logic        vgaEnable = 1'b0;
  logic        claim;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // independent model of the shadows
  bit       mIoSel = 0;
  bit [1:0] mMap = 0;
  bit [2:0] mIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_claim_filter u_vga_claim_filter (
    .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycIsIo(cycIsIo),
    .cycWrite(cycWrite), .cycAddr(cycAddr), .cycByteEn(cycByteEn),
    .cycWrData(cycWrData), .vgaEnable(vgaEnable), .claim(claim)
  );

  function automatic bit expClaim(bit io, bit [31:0] a);
    if (!vgaEnable) return 0;
    if (io) begin
      if (a >= 32'h3C0 && a <= 32'h3CF) return 1;
      if (a >= 32'h3B0 && a <= 32'h3BF) return !mIoSel;
      if (a >= 32'h3D0 && a <= 32'h3DF) return mIoSel;
      return 0;
    end
    case (mMap)
      2'd0: return a >= 32'hA0000 && a <= 32'hBFFFF;
      2'd1: return a >= 32'hA0000 && a <= 32'hAFFFF;
      2'd2: return a >= 32'hB0000 && a <= 32'hB7FFF;
      default: return a >= 32'hB8000 && a <= 32'hBFFFF;
    endcase
  endfunction

  task automatic cyc(input bit io, input bit wr, input bit [31:0] a,
                     input bit [1:0] be, input bit [15:0] d, input string tag);
    bit e;
    @(negedge clk);
    cycValid = 1; cycIsIo = io; cycWrite = wr; cycAddr = a;
    cycByteEn = be; cycWrData = d;
    #1;
    e = expClaim(io, a);
    nChecks++;
    if (claim !== e) begin
      nFails++;
      $display("FAIL %s io=%0d addr=%h claim=%0b expected=%0b", tag, io, a, claim, e);
    end
    @(posedge clk);
    if (io && wr && vgaEnable) begin
      for (int k = 0; k < 2; k++) begin
        if (be[k]) begin
          bit [31:0] la = a + k;
          bit [7:0]  b  = d[8*k +: 8];
          if (la == 32'h3C2) mIoSel = b[0];
          if (la == 32'h3CE) mIdx = b[2:0];
          if (la == 32'h3CF && mIdx == 3'd6) mMap = b[3:2];
        end
      end
    end
    #1;
    cycValid = 0;
  endtask

  task automatic sweep(input string tag);
    bit [31:0] edges [8] = '{32'h9FFFF, 32'hA0000, 32'hAFFFF, 32'hB0000,
                             32'hB7FFF, 32'hB8000, 32'hBFFFF, 32'hC0000};
    for (int p = 32'h3A0; p <= 32'h3EF; p++) cyc(1, 0, p, 2'b01, 0, tag);
    for (int m = 32'h9F000; m <= 32'hC0FFF; m += 32'h400) cyc(0, 0, m, 2'b11, 0, tag);
    for (int i = 0; i < 8; i++) cyc(0, 0, edges[i], 2'b11, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    vgaEnable = 1;
    sweep("R1 reset decode");

    // R3 R5 R7: every select combination, map set by a paired 16-bit write
    for (int s = 0; s < 2; s++) begin
      for (int mp = 0; mp < 4; mp++) begin
        cyc(1, 1, 32'h3C2, 2'b01, 16'(s), "R3 misc write");
        cyc(1, 1, 32'h3CE, 2'b11, {4'b0, 2'(mp), 2'b0, 8'h06}, "R7 paired write");
        sweep("R3 R4 R5 R9 sweep");
      end
    end

    // R6: data under wrong index ignored, read of index port ignored
    cyc(1, 1, 32'h3CE, 2'b01, 16'h0005, "R6 index 5");
    cyc(1, 1, 32'h3CF, 2'b01, 16'h0004, "R6 data wrong index");
    cyc(0, 0, 32'hA0000, 2'b11, 0, "R6 map unchanged");
    cyc(1, 0, 32'h3CE, 2'b01, 16'h0006, "R6 read index port");
    cyc(1, 1, 32'h3CF, 2'b01, 16'h0008, "R6 data after read");
    cyc(0, 0, 32'hB0000, 2'b11, 0, "R6 map still unchanged");
    cyc(1, 1, 32'h3CE, 2'b01, 16'h0006, "R6 index 6");
    cyc(1, 1, 32'h3CF, 2'b01, 16'h0004, "R6 data index 6");
    // R8: the next cycle already sees map 01
    cyc(0, 0, 32'hB8000, 2'b11, 0, "R8 next cycle map");
    cyc(0, 0, 32'hA0000, 2'b11, 0, "R8 next cycle map");
    // R7 variant: index on high lane from 0x3CD
    cyc(1, 1, 32'h3CD, 2'b10, 16'h0600, "R7 high lane index");
    cyc(1, 1, 32'h3CF, 2'b01, 16'h0008, "R7 data after high-lane index");
    cyc(0, 0, 32'hB0000, 2'b11, 0, "R7 map 10");
    // R9: off-lane enable at 0x3C2 does nothing
    cyc(1, 1, 32'h3C2, 2'b10, 16'h0101, "R9 lane off");
    cyc(1, 1, 32'h3B4, 2'b11, 0, "R9 lane off mono");
    cyc(1, 1, 32'h3D4, 2'b11, 0, "R9 lane off color");
    // R8: port select flip visible next cycle
    cyc(1, 1, 32'h3C2, 2'b01, 16'h0001, "R8 misc flip");
    cyc(1, 0, 32'h3D4, 2'b01, 0, "R8 color next cycle");
    cyc(1, 0, 32'h3B4, 2'b01, 0, "R8 mono next cycle");

    // R2: disabled, nothing claimed and writes ignored
    vgaEnable = 0;
    sweep("R2 disabled sweep");
    cyc(1, 1, 32'h3C2, 2'b01, 16'h0000, "R2 misc write off");
    cyc(1, 1, 32'h3CE, 2'b11, 16'h0C06, "R2 map write off");
    @(negedge clk);
    vgaEnable = 1;
    sweep("R2 shadows kept");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule